// File: doc/BRIEF.md
# Compare-Restart Up-Counting Timer

This block is a general-purpose up-counter with a small register interface. Software selects one of three tick-enable sources, picks between two counting modes, and loads a compare value. The counter advances by one on each selected tick while the timer is enabled. A compare-match flag is raised when a tick arrives while the count equals the compare value.

In restart mode the count returns to zero on the tick that finds it equal to the compare value, so the timer produces a fixed period of compare+1 ticks. In free-running mode the compare match only raises the flag. The count always wraps from the all-ones value to zero. The source-select field is a sparse 3-bit code, and every unassigned code freezes the counter.

Top module: `cmp_restart_timer`

## Requirements
- R1: The counter changes only on a selected tick while the enable bit (control bit 0) is 1. While enable is 0 it holds its value.
- R2: A selected tick that finds the count at its all-ones value makes the count 0 on the next cycle.
- R3: In restart mode (control bit 1 = 0), a selected tick that finds the count equal to the compare value makes the count 0 instead of count+1.
- R4: In free-running mode (control bit 1 = 1), a compare match does not alter the count. The count keeps incrementing by one per selected tick.
- R5: The source field in control bits [4:2] selects the tick. 3'b001 selects `tick_periph`, 3'b010 selects `tick_fast` and 3'b100 selects `tick_slow`. Ticks on the unselected inputs have no effect.
- R6: A selected tick while enabled and while the count equals the compare value sets the match flag. This holds in both modes. The flag appears on `match_flag` and in status bit 0 (address 3).
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set. If a new match arrives in the same cycle as the clear, the set wins.
- R8: Source codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 select no tick, so the counter holds.
- R9: After reset the control, compare, counter and flag read 0, and the timer is disabled.
- R10: A control write that takes enable from 0 to 1 clears the counter to 0. Counting starts on the following cycle.
- R11: Address 0 is control, address 1 is compare, address 2 is the counter (read-only, so writes are ignored) and address 3 is status. `rdata` shows the addressed register in the same cycle, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| tick_periph | input | 1 | Peripheral tick enable |
| tick_fast | input | 1 | High-frequency tick enable |
| tick_slow | input | 1 | Slow (32 kHz) tick enable |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The hardest situation to reach from the ports is the all-ones wrap, because the count has to walk through its entire range first. The bench therefore builds the counter at 8 bits and pushes it from a known value up to 255 with a long train of ticks, then checks that the next tick gives 0. Restart-mode clearing and free-running pass-through both use the same compare value. Every unassigned source code is driven with all three ticks pulsed at once, to show that none of them reaches the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] REG_CMP  = 2'd1;
   localparam logic [ADDR_W-1:0] REG_CNT  = 2'd2;
   localparam logic [ADDR_W-1:0] REG_STAT = 2'd3;

   localparam logic [2:0] SRC_PERIPH = 3'b001;
   localparam logic [2:0] SRC_FAST   = 3'b010;
   localparam logic [2:0] SRC_SLOW   = 3'b100;

   localparam int unsigned CTRL_W = 5;

   typedef struct packed {
      logic [2:0] src;
      logic       free_run;
      logic       enable;
   } ctrl_t;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
   import tmr_pkg::*;
(
   input  logic [2:0] src,
   input  logic       tick_periph,
   input  logic       tick_fast,
   input  logic       tick_slow,
   output logic       tick
);
   always_comb begin
      unique case (src)
         SRC_PERIPH: tick = tick_periph;
         SRC_FAST:   tick = tick_fast;
         SRC_SLOW:   tick = tick_slow;
         default:    tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             enable,
   input  logic             free_run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt,
   output logic             match_set
);
   logic step;
   logic hit;

   assign step      = enable && tick;
   assign hit       = step && (cnt == cmp);
   assign match_set = hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= '0;
      end else if (step) begin
         if (hit && !free_run) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              flag_set,
   input  logic [CNT_W-1:0]  cnt,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  cmp,
   output logic              flag,
   output logic              start,
   output logic [DATA_W-1:0] rdata
);
   logic wr_ctrl, wr_cmp, wr_stat;

   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign wr_cmp  = wr_en && (addr == REG_CMP);
   assign wr_stat = wr_en && (addr == REG_STAT);
   assign start   = wr_ctrl && wdata[0] && !ctrl.enable;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         cmp  <= '0;
         flag <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_cmp)  cmp  <= wdata[CNT_W-1:0];
         if (flag_set)                flag <= 1'b1;
         else if (wr_stat && wdata[0]) flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_CTRL: rdata[CTRL_W-1:0] = ctrl;
         REG_CMP:  rdata[CNT_W-1:0]  = cmp;
         REG_CNT:  rdata[CNT_W-1:0]  = cnt;
         default:  rdata[0]          = flag;
      endcase
   end
endmodule

// File: rtl/cmp_restart_timer.sv
module cmp_restart_timer
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tick_periph,
   input  logic              tick_fast,
   input  logic              tick_slow,
   output logic              match_flag
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data_w
         $error("DATA_W too narrow for control field");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sel_tick;
   logic             start_pulse;
   logic             hit_set;

   tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .flag_set(hit_set), .cnt(cnt_q), .ctrl(ctrl_q), .cmp(cmp_q),
      .flag(match_flag), .start(start_pulse), .rdata(rdata)
   );

   tmr_tick_sel u_sel (
      .src(ctrl_q.src), .tick_periph(tick_periph), .tick_fast(tick_fast),
      .tick_slow(tick_slow), .tick(sel_tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start_pulse), .enable(ctrl_q.enable),
      .free_run(ctrl_q.free_run), .tick(sel_tick), .cmp(cmp_q),
      .cnt(cnt_q), .match_set(hit_set)
   );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic              en,
   input logic              fr,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic              flag
);
   logic ctrl_wr;
   assign ctrl_wr = wr_en && (addr == 2'd0);

   p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ctrl_wr) |=> $stable(cnt));

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && cnt == '1) |=> (cnt == '0));

   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !fr && cnt == cmp) |=> (cnt == '0));

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && fr && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

   p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && cnt == cmp) |=> flag);

   p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !en && wdata[0]) |=> (cnt == '0));
endmodule

bind cmp_restart_timer tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .en(ctrl_q.enable), .fr(ctrl_q.free_run), .tick(sel_tick),
   .cnt(cnt_q), .cmp(cmp_q), .flag(match_flag)
);

// File: tb/cmp_restart_timer_bench.sv
module cmp_restart_timer_bench;
   localparam int DW = 32;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          t_per = 1'b0, t_fst = 1'b0, t_slw = 1'b0;
   logic          match_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmp_restart_timer #(.DATA_W(DW), .CNT_W(CW)) u_cmp_restart_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tick_periph(t_per), .tick_fast(t_fst), .tick_slow(t_slw),
      .match_flag(match_flag)
   );

   typedef struct {
      bit          is_flag;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   event  sample_ev;

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(sample_ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_flag ? {31'd0, match_flag} : rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      addr = a;
      it.is_flag = 0; it.exp = e; it.tag = tag;
      q.push_back(it);
      -> sample_ev;
      #2;
   endtask

   task automatic expect_flag(input bit e, input string tag);
      item_t it;
      @(negedge clk);
      it.is_flag = 1; it.exp = {31'd0, e}; it.tag = tag;
      q.push_back(it);
      -> sample_ev;
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // which: 1 periph, 2 fast, 4 slow (bitmask)
   task automatic ticks(input int which, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         t_per = which[0]; t_fst = which[1]; t_slw = which[2];
         @(negedge clk);
         t_per = 0; t_fst = 0; t_slw = 0;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      expect_reg(2'd0, 0, "R9 ctrl");
      expect_reg(2'd1, 0, "R9 cmp");
      expect_reg(2'd2, 0, "R9 cnt");
      expect_reg(2'd3, 0, "R9 status");
      expect_flag(0, "R9 flag");

      wr(2'd1, 32'd5);
      expect_reg(2'd1, 5, "R11 cmp readback");
      wr(2'd0, 32'h05);               // enable, restart, periph
      expect_reg(2'd0, 32'h05, "R11 ctrl readback");
      ticks(1, 3);
      expect_reg(2'd2, 3, "R5 periph ticks");
      ticks(2, 2); ticks(4, 2);
      expect_reg(2'd2, 3, "R5 unselected ignored");

      wr(2'd0, 32'h04);               // disable
      ticks(1, 4);
      expect_reg(2'd2, 3, "R1 hold while disabled");

      wr(2'd0, 32'h05);               // re-enable
      expect_reg(2'd2, 0, "R10 clear on enable");
      ticks(1, 5);
      expect_reg(2'd2, 5, "R3 reach compare");
      expect_flag(0, "R6 no flag before match tick");
      ticks(1, 1);
      expect_reg(2'd2, 0, "R3 restart clear");
      expect_flag(1, "R6 flag set restart");
      ticks(1, 1);
      expect_reg(2'd2, 1, "R3 count after restart");
      wr(2'd3, 32'd0);
      expect_reg(2'd3, 1, "R7 write 0 keeps flag");
      wr(2'd3, 32'd1);
      expect_flag(0, "R7 write 1 clears");

      wr(2'd0, 32'h0B);               // enable, free-run, fast
      expect_reg(2'd2, 1, "R10 no clear when already enabled");
      ticks(2, 4);
      expect_reg(2'd2, 5, "R5 fast ticks");
      ticks(2, 1);
      expect_reg(2'd2, 6, "R4 free-run passes compare");
      expect_flag(1, "R6 flag set free-run");
      wr(2'd3, 32'd1);
      ticks(2, 249);
      expect_reg(2'd2, 255, "R2 reach all ones");
      expect_flag(0, "R7 flag stays clear");
      ticks(2, 1);
      expect_reg(2'd2, 0, "R2 wrap to zero");

      wr(2'd0, 32'h13);               // slow source
      ticks(4, 3);
      expect_reg(2'd2, 3, "R5 slow ticks");

      for (int s = 0; s < 8; s++) begin
         if (s == 1 || s == 2 || s == 4) continue;
         wr(2'd0, (s << 2) | 3);
         ticks(7, 2);
         expect_reg(2'd2, 3, $sformatf("R8 code %0d holds", s));
      end

      wr(2'd2, 32'h55);
      expect_reg(2'd2, 3, "R11 counter write ignored");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule